// File: doc/BRIEF.md
# Cascaded One-Hot Tally Counter

This block counts how many bits of an N-bit input word are set and reports the total as a one-hot code of N+1 lines. Line k is high when exactly k inputs are 1. The code is formed by a chain of identical steering stages, one for each input bit. A one-hot token enters the chain at line 0. A stage whose input bit is 0 passes every line through unchanged. A stage whose input bit is 1 moves every line up by one position and drives its lowest line to a hard 0. The token therefore climbs one line for each set bit, and no line is ever left undriven.

A binary form of the same count, of width clog2(N+1), is also given. By default the result is registered: a word presented with `in_valid` appears on the outputs one clock later together with `out_valid`. A synchronous reset returns the outputs to the code for zero. With `REGISTERED` set to 0 the outputs follow the input combinationally, and `out_valid` mirrors `in_valid`.

Top module: `tally_onehot`

## Requirements
- R1: `onehot` has exactly one bit set in every cycle after reset.
- R2: The set bit of `onehot` sits at the index equal to the number of 1 bits in the sampled word. An all-zero word gives bit 0 (the zero code, value 1).
- R3: An all-ones word gives bit N of `onehot`, the top line.
- R4: Only the number of set bits matters, not their positions. For example, with two inputs, 01 and 10 both give line 1, and 11 gives line 2.
- R5: `count` is the binary index of the set bit of `onehot`. Its width is clog2(N+1).
- R6: With the registered output, a word sampled with `in_valid` high at a rising edge appears on `onehot` and `count` after that edge, and `out_valid` is high for that cycle.
- R7: When `in_valid` is low at an edge, `onehot` and `count` keep their values and `out_valid` is low in the following cycle.
- R8: Synchronous reset `rst` (active high) sets `onehot` to 1, `count` to 0 and `out_valid` to 0, even while `in_valid` is high.
- R9: No output bit is ever unknown after the first reset edge.

Top module port list:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies `in_bits` for sampling |
| in_bits | input | N | Word whose set bits are counted |
| onehot | output | N+1 | One-hot tally, bit k means k ones |
| count | output | clog2(N+1) | Binary index of the set line |
| out_valid | output | 1 | High one cycle after a sampled word |

## Verification
The hardest cases to reach are the extreme lines, where the token must either leave line 0 untouched through every stage or move through all N stages to the top. Near those lines, one wrong shift or one undriven bottom line shows up only for a few specific words. The stimulus drives the all-zero and all-ones words, walks a single 1 and a single 0 across every position, and adds every pair of set bits. These are followed by pseudo-random words mixed with idle gaps and a reset asserted while a word is still being presented.

// File: rtl/tally_onehot.sv
module tally_onehot #(
  parameter int N = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int W = N + 1,
  localparam int CW = (N + 1 > 1) ? $clog2(N + 1) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [N-1:0]  in_bits,
  output logic [W-1:0]  onehot,
  output logic [CW-1:0] count,
  output logic          out_valid
);

  logic [W-1:0] chain [0:N];
  logic [CW-1:0] enc;

  assign chain[0] = W'(1);

  for (genvar k = 0; k < N; k++) begin : g_stage
    assign chain[k+1] = in_bits[k] ? {chain[k][W-2:0], 1'b0} : chain[k];
  end

  always_comb begin
    enc = '0;
    for (int j = 0; j < W; j++)
      if (chain[N][j]) enc = enc | CW'(j);
  end

  if (REGISTERED) begin : g_reg
    logic [W-1:0]  oh_q;
    logic [CW-1:0] cnt_q;
    logic          v_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        oh_q  <= W'(1);
        cnt_q <= '0;
        v_q   <= 1'b0;
      end else begin
        v_q <= in_valid;
        if (in_valid) begin
          oh_q  <= chain[N];
          cnt_q <= enc;
        end
      end
    end
    assign onehot    = oh_q;
    assign count     = cnt_q;
    assign out_valid = v_q;
  end else begin : g_comb
    assign onehot    = chain[N];
    assign count     = enc;
    assign out_valid = in_valid;
  end

endmodule

// File: rtl/tally_onehot_chk.sv
module tally_onehot_chk #(
  parameter int N = 8,
  parameter bit REGISTERED = 1'b1,
  localparam int W = N + 1,
  localparam int CW = (N + 1 > 1) ? $clog2(N + 1) : 1
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic [N-1:0]  in_bits,
  input logic [W-1:0]  onehot,
  input logic [CW-1:0] count,
  input logic          out_valid
);

  a_r1_single_line: assert property (@(posedge clk) disable iff (rst)
    $countones(onehot) == 1);

  a_r5_binary_agrees: assert property (@(posedge clk) disable iff (rst)
    onehot == (W'(1) << count));

  if (REGISTERED) begin : g_seq
    a_r2_tally_value: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> (32'(count) == $countones($past(in_bits))));

    a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(onehot) && $stable(count)));

    a_r8_reset_zero_code: assert property (@(posedge clk)
      rst |=> (onehot == W'(1) && count == '0 && !out_valid));
  end

endmodule

bind tally_onehot tally_onehot_chk #(.N(N), .REGISTERED(REGISTERED)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
  .onehot(onehot), .count(count), .out_valid(out_valid)
);

// File: tb/tally_onehot_test.sv
module tally_onehot_test;
  localparam int N = 8;
  localparam int W = N + 1;
  localparam int CW = $clog2(N + 1);
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [N-1:0] in_bits = '0;
  logic [W-1:0] onehot;
  logic [CW-1:0] count;
  logic out_valid;

  int compared = 0;
  int mismatched = 0;
  int exp_cnt = 0;
  bit exp_v = 1'b0;
  string tag = "R8";
  bit done = 1'b0;

  tally_onehot #(.N(N), .REGISTERED(1'b1)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_bits(in_bits),
    .onehot(onehot), .count(count), .out_valid(out_valid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference: updated on the same edge the design registers
  always @(posedge clk) begin
    if (rst) begin
      exp_cnt <= 0;
      exp_v   <= 1'b0;
    end else begin
      exp_v <= in_valid;
      if (in_valid) exp_cnt <= $countones(in_bits);
    end
  end

  task automatic check_now();
    logic [W-1:0] exp_oh;
    exp_oh = '0;
    exp_oh[exp_cnt] = 1'b1;
    compared++;
    if ($isunknown({onehot, count, out_valid})) begin
      mismatched++;
      $display("FAIL R9 unknown output actual %b/%b/%b expected known", onehot, count, out_valid);
    end else if ($countones(onehot) != 1) begin
      mismatched++;
      $display("FAIL R1 onehot actual %b expected one bit set (%b)", onehot, exp_oh);
    end else if (onehot !== exp_oh) begin
      mismatched++;
      $display("FAIL %s onehot actual %b expected %b", tag, onehot, exp_oh);
    end else if (32'(count) != exp_cnt) begin
      mismatched++;
      $display("FAIL R5 count actual %0d expected %0d", count, exp_cnt);
    end else if (out_valid !== exp_v) begin
      mismatched++;
      $display("FAIL %s out_valid actual %b expected %b", (exp_v ? "R6" : "R7"), out_valid, exp_v);
    end
  endtask

  always @(negedge clk) if (!done) check_now();

  task automatic drive(input bit v, input logic [N-1:0] b, input string t);
    @(negedge clk);
    #1;
    tag = t;
    in_valid = v;
    in_bits = b;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      mismatched++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R8: reset state
    repeat (3) @(posedge clk);
    drive(1'b0, '0, "R8");
    rst = 1'b0;
    // R2: zero word gives zero code
    drive(1'b1, '0, "R2");
    // R3: all ones reaches top line
    drive(1'b1, '1, "R3");
    drive(1'b1, '0, "R2");
    drive(1'b1, '1, "R3");
    // R7: idle holds value with valid low
    drive(1'b0, 8'h0F, "R7");
    drive(1'b0, 8'hA5, "R7");
    drive(1'b0, '0, "R7");
    // R4: walking single one and single zero
    for (int i = 0; i < N; i++) drive(1'b1, N'(1) << i, "R4");
    for (int i = 0; i < N; i++) drive(1'b1, ~(N'(1) << i), "R4");
    // R4: every pair of set bits
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        drive(1'b1, (N'(1) << i) | (N'(1) << j), "R4");
    // R2/R6: random words with idle gaps
    for (int i = 0; i < 400; i++)
      drive(($urandom % 4) != 0, N'($urandom), "R2");
    // R8: reset while a word is presented
    drive(1'b1, '1, "R6");
    @(negedge clk);
    #1;
    tag = "R8";
    rst = 1'b1;
    in_bits = 8'h7E;
    drive(1'b1, 8'h3C, "R8");
    rst = 1'b0;
    drive(1'b0, '0, "R6");
    drive(1'b1, 8'h81, "R6");
    drive(1'b0, '0, "R7");
    repeat (3) @(negedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule